// File: doc/BRIEF.md
# Memory Descriptor Admission Unit

This block sits behind the matching stage of a message-passing network interface. For each operation that has already been matched to a memory descriptor, it decides whether the descriptor takes the operation in full, takes a shortened version of it, or refuses it. The block receives the operation type (put or get), the requested length, an offset supplied by the initiator and a flag showing whether the initiator wants an acknowledgment.

For an admitted operation, the block reports the start offset inside the region and the number of bytes granted. It also reports whether an acknowledgment has to go back to the initiator. In the same step it updates the descriptor's own state: the running offset, the remaining operation count (the threshold) and the active flag. The descriptor is set up through a small register-write port. The data movement and the event reporting happen elsewhere.

Each descriptor keeps a threshold of operations, which can also be set to infinite. The offset is managed either locally or by the initiator. Oversized requests can optionally be truncated. A descriptor can also be retired once its unused space falls below a configured minimum.

Top module: `md_admit`

## Requirements
- R1: After reset, `rsp_valid_o` is 0, `md_active_o` is 0, and `md_offset_o` and `md_thresh_o` are 0.
- R2: A put is refused when control bit 0 (put enable) is clear. A get is refused when control bit 1 (get enable) is clear.
- R3: While `md_active_o` is 0, every request is refused and the descriptor state does not change.
- R4: Each admitted operation lowers a finite, nonzero threshold by one. When the threshold reaches zero, `md_active_o` drops.
- R5: A threshold of all ones (2^THR_W-1) means infinite. It is never lowered, and it never makes the descriptor inactive.
- R6: When control bit 2 is clear (local offset), an admitted operation starts at the current offset, and `md_offset_o` then advances by the granted length.
- R7: When control bit 2 is set (remote offset), the start offset is `req_roff_i`, and `md_offset_o` does not change.
- R8: When truncation is off (control bit 3 clear), a request longer than the remaining space (region length minus start offset, or 0 if the start offset is past the end) is refused and the state does not change. A refusal reports length 0, offset 0, no truncation flag and no acknowledgment.
- R9: When control bit 3 is set, an oversized request is admitted with its length cut to the remaining space, which may be 0, and `rsp_trunc_o` is set.
- R10: When control bit 4 is set and the offset is local, the descriptor becomes inactive once an admitted operation leaves less unused space than the minimum-free register holds. The rule is not applied when the offset is remote.
- R11: `rsp_ack_o` is 1 only for an admitted put whose initiator asked for an acknowledgment while control bit 5 (ack suppress) is clear.
- R12: The result of a request appears exactly one cycle after the cycle in which `req_valid_i` is sampled. `rsp_valid_o` is high only in that cycle.
- R13: Register-write addresses are: 3 for region length, 1 for threshold (low THR_W bits), 2 for minimum free space, and 0 for control. A write to control also arms the descriptor: the offset becomes 0 and the descriptor turns active if the threshold is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Descriptor register write strobe |
| cfg_addr_i | input | 2 | Descriptor register address |
| cfg_wdata_i | input | LEN_W | Descriptor register write data |
| req_valid_i | input | 1 | Matched operation present |
| req_is_get_i | input | 1 | 1 = get, 0 = put |
| req_len_i | input | LEN_W | Requested length |
| req_roff_i | input | LEN_W | Offset supplied by the initiator |
| req_ack_req_i | input | 1 | Initiator asks for an acknowledgment |
| rsp_valid_o | output | 1 | Decision valid |
| rsp_accept_o | output | 1 | Operation admitted |
| rsp_trunc_o | output | 1 | Admitted with reduced length |
| rsp_offset_o | output | LEN_W | Start offset of the admitted operation |
| rsp_len_o | output | LEN_W | Granted length |
| rsp_ack_o | output | 1 | Acknowledgment must be sent |
| md_active_o | output | 1 | Descriptor is active |
| md_offset_o | output | LEN_W | Current local offset |
| md_thresh_o | output | THR_W | Current threshold |

## Verification
The bench builds the block with LEN_W=8 and THR_W=4. With these values the infinite threshold code is 15, so short regions of 40 to 100 bytes can be used up in a few operations. Threshold exhaustion, exact-fit and zero-length truncation, and the minimum-free-space boundary are all reached within a few dozen cycles. A behavioural model tracks offset, threshold and active state across several re-armed configurations, covering local and remote offset, truncation, acknowledgment suppression and type filtering.

// File: rtl/md_admit_pkg.sv
package md_admit_pkg;

  typedef enum logic [1:0] {
    MD_REG_CTRL    = 2'd0,
    MD_REG_THRESH  = 2'd1,
    MD_REG_MINFREE = 2'd2,
    MD_REG_LEN     = 2'd3
  } md_reg_e;

  typedef struct packed {
    logic ack_sup;
    logic max_en;
    logic trunc_en;
    logic remote;
    logic allow_get;
    logic allow_put;
  } md_flags_t;

  localparam int unsigned MD_FLAG_W = 6;

endpackage

// File: rtl/md_admit_decide.sv
module md_admit_decide
  import md_admit_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned THR_W = 8
) (
  input  md_flags_t          flags_i,
  input  logic               active_i,
  input  logic [LEN_W-1:0]   cur_off_i,
  input  logic [LEN_W-1:0]   region_len_i,
  input  logic [LEN_W-1:0]   min_free_i,
  input  logic [THR_W-1:0]   thr_i,
  input  logic               is_get_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [LEN_W-1:0]   roff_i,
  input  logic               ack_req_i,
  output logic               accept_o,
  output logic               trunc_o,
  output logic [LEN_W-1:0]   base_o,
  output logic [LEN_W-1:0]   grant_o,
  output logic               ack_o,
  output logic [LEN_W-1:0]   nxt_off_o,
  output logic [THR_W-1:0]   nxt_thr_o,
  output logic               nxt_active_o
);

  localparam logic [THR_W-1:0] THR_INF = {THR_W{1'b1}};
  localparam logic [THR_W-1:0] THR_ONE = THR_W'(1);

  logic [LEN_W-1:0] remaining;
  logic [LEN_W-1:0] free_after;
  logic             fits, type_ok, thr_dec, low_space, exhausted;

  always_comb begin
    base_o    = flags_i.remote ? roff_i : cur_off_i;
    remaining = (base_o <= region_len_i) ? region_len_i - base_o : '0;
    fits      = (len_i <= remaining);
    type_ok   = is_get_i ? flags_i.allow_get : flags_i.allow_put;
    accept_o  = active_i && type_ok && (fits || flags_i.trunc_en);
    trunc_o   = accept_o && !fits;
    grant_o   = fits ? len_i : remaining;
    ack_o     = accept_o && !is_get_i && ack_req_i && !flags_i.ack_sup;

    nxt_off_o = (accept_o && !flags_i.remote) ? cur_off_i + grant_o : cur_off_i;

    thr_dec   = accept_o && (thr_i != THR_INF) && (thr_i != '0);
    nxt_thr_o = thr_dec ? thr_i - THR_ONE : thr_i;
    exhausted = thr_dec && (thr_i == THR_ONE);

    // unused space after the update; guarded if region shrank under the offset
    free_after = (nxt_off_o <= region_len_i) ? region_len_i - nxt_off_o : '0;
    low_space  = accept_o && flags_i.max_en && !flags_i.remote &&
                 (free_after < min_free_i);

    nxt_active_o = active_i && !exhausted && !low_space;
  end

endmodule

// File: rtl/md_admit_state.sv
module md_admit_state
  import md_admit_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned THR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_addr_i,
  input  logic [LEN_W-1:0]   cfg_wdata_i,
  input  logic               upd_i,
  input  logic [LEN_W-1:0]   nxt_off_i,
  input  logic [THR_W-1:0]   nxt_thr_i,
  input  logic               nxt_active_i,
  output md_flags_t          flags_o,
  output logic [LEN_W-1:0]   region_len_o,
  output logic [LEN_W-1:0]   min_free_o,
  output logic [THR_W-1:0]   thr_o,
  output logic [LEN_W-1:0]   off_o,
  output logic               active_o
);

  md_reg_e waddr;
  assign waddr = md_reg_e'(cfg_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o      <= '0;
      region_len_o <= '0;
      min_free_o   <= '0;
      thr_o        <= '0;
      off_o        <= '0;
      active_o     <= 1'b0;
    end else if (cfg_we_i) begin
      // configuration has priority over a same-cycle request update
      unique case (waddr)
        MD_REG_CTRL: begin
          flags_o  <= md_flags_t'(cfg_wdata_i[MD_FLAG_W-1:0]);
          off_o    <= '0;
          active_o <= (thr_o != '0);
        end
        MD_REG_THRESH:  thr_o        <= cfg_wdata_i[THR_W-1:0];
        MD_REG_MINFREE: min_free_o   <= cfg_wdata_i;
        MD_REG_LEN:     region_len_o <= cfg_wdata_i;
        default: ;
      endcase
    end else if (upd_i) begin
      off_o    <= nxt_off_i;
      thr_o    <= nxt_thr_i;
      active_o <= nxt_active_i;
    end
  end

endmodule

// File: rtl/md_admit.sv
module md_admit
  import md_admit_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned THR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_addr_i,
  input  logic [LEN_W-1:0]   cfg_wdata_i,
  input  logic               req_valid_i,
  input  logic               req_is_get_i,
  input  logic [LEN_W-1:0]   req_len_i,
  input  logic [LEN_W-1:0]   req_roff_i,
  input  logic               req_ack_req_i,
  output logic               rsp_valid_o,
  output logic               rsp_accept_o,
  output logic               rsp_trunc_o,
  output logic [LEN_W-1:0]   rsp_offset_o,
  output logic [LEN_W-1:0]   rsp_len_o,
  output logic               rsp_ack_o,
  output logic               md_active_o,
  output logic [LEN_W-1:0]   md_offset_o,
  output logic [THR_W-1:0]   md_thresh_o
);

  md_flags_t        flags;
  logic [LEN_W-1:0] region_len, min_free, cur_off;
  logic [THR_W-1:0] thr;
  logic             active;

  logic             d_accept, d_trunc, d_ack, d_nxt_active;
  logic [LEN_W-1:0] d_base, d_grant, d_nxt_off;
  logic [THR_W-1:0] d_nxt_thr;

  md_admit_decide #(.LEN_W(LEN_W), .THR_W(THR_W)) u_decide (
    .flags_i      (flags),
    .active_i     (active),
    .cur_off_i    (cur_off),
    .region_len_i (region_len),
    .min_free_i   (min_free),
    .thr_i        (thr),
    .is_get_i     (req_is_get_i),
    .len_i        (req_len_i),
    .roff_i       (req_roff_i),
    .ack_req_i    (req_ack_req_i),
    .accept_o     (d_accept),
    .trunc_o      (d_trunc),
    .base_o       (d_base),
    .grant_o      (d_grant),
    .ack_o        (d_ack),
    .nxt_off_o    (d_nxt_off),
    .nxt_thr_o    (d_nxt_thr),
    .nxt_active_o (d_nxt_active)
  );

  md_admit_state #(.LEN_W(LEN_W), .THR_W(THR_W)) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_we_i     (cfg_we_i),
    .cfg_addr_i   (cfg_addr_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .upd_i        (req_valid_i),
    .nxt_off_i    (d_nxt_off),
    .nxt_thr_i    (d_nxt_thr),
    .nxt_active_i (d_nxt_active),
    .flags_o      (flags),
    .region_len_o (region_len),
    .min_free_o   (min_free),
    .thr_o        (thr),
    .off_o        (cur_off),
    .active_o     (active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_accept_o <= 1'b0;
      rsp_trunc_o  <= 1'b0;
      rsp_offset_o <= '0;
      rsp_len_o    <= '0;
      rsp_ack_o    <= 1'b0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      rsp_accept_o <= req_valid_i && d_accept;
      rsp_trunc_o  <= req_valid_i && d_trunc;
      rsp_offset_o <= (req_valid_i && d_accept) ? d_base : '0;
      rsp_len_o    <= (req_valid_i && d_accept) ? d_grant : '0;
      rsp_ack_o    <= req_valid_i && d_ack;
    end
  end

  assign md_active_o = active;
  assign md_offset_o = cur_off;
  assign md_thresh_o = thr;

endmodule

// File: rtl/md_admit_chk.sv
module md_admit_chk #(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned THR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             req_valid_i,
  input logic             req_is_get_i,
  input logic             req_ack_req_i,
  input logic             rsp_valid_o,
  input logic             rsp_accept_o,
  input logic             rsp_trunc_o,
  input logic [LEN_W-1:0] rsp_len_o,
  input logic [LEN_W-1:0] rsp_offset_o,
  input logic             rsp_ack_o,
  input logic             md_active_o,
  input logic [LEN_W-1:0] md_offset_o,
  input logic [THR_W-1:0] md_thresh_o
);

  localparam logic [THR_W-1:0] THR_INF = {THR_W{1'b1}};

  assert_rsp_follows_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_no_spurious_rsp_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_reject_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_accept_o) |->
      (rsp_len_o == '0 && rsp_offset_o == '0 && !rsp_trunc_o && !rsp_ack_o));

  assert_trunc_implies_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_trunc_o |-> rsp_accept_o);

  assert_ack_only_put_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_is_get_i || !req_ack_req_i)) |=> !rsp_ack_o);

  assert_inactive_rejects_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !md_active_o && !cfg_we_i) |=>
      (!rsp_accept_o && $stable(md_offset_o) && $stable(md_thresh_o)));

  assert_infinite_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (md_thresh_o == THR_INF && !cfg_we_i) |=> (md_thresh_o == THR_INF));

  assert_idle_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && !cfg_we_i) |=>
      ($stable(md_offset_o) && $stable(md_thresh_o) && $stable(md_active_o)));

endmodule

bind md_admit md_admit_chk #(.LEN_W(LEN_W), .THR_W(THR_W)) u_md_admit_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_we_i      (cfg_we_i),
  .req_valid_i   (req_valid_i),
  .req_is_get_i  (req_is_get_i),
  .req_ack_req_i (req_ack_req_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_accept_o  (rsp_accept_o),
  .rsp_trunc_o   (rsp_trunc_o),
  .rsp_len_o     (rsp_len_o),
  .rsp_offset_o  (rsp_offset_o),
  .rsp_ack_o     (rsp_ack_o),
  .md_active_o   (md_active_o),
  .md_offset_o   (md_offset_o),
  .md_thresh_o   (md_thresh_o)
);

// File: tb/md_admit_tb_top.sv
`timescale 1ns/1ps
module md_admit_tb_top;

  localparam int LW  = 8;
  localparam int TW  = 4;
  localparam int INF = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [LW-1:0] cfg_wdata = '0;
  logic          req_v = 1'b0;
  logic          req_get = 1'b0;
  logic [LW-1:0] req_len = '0;
  logic [LW-1:0] req_roff = '0;
  logic          req_ack = 1'b0;
  logic          rsp_valid, rsp_accept, rsp_trunc, rsp_ack, md_active;
  logic [LW-1:0] rsp_offset, rsp_len, md_offset;
  logic [TW-1:0] md_thresh;

  always #2.5 clk = ~clk;

  md_admit #(.LEN_W(LW), .THR_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .req_valid_i(req_v), .req_is_get_i(req_get), .req_len_i(req_len),
    .req_roff_i(req_roff), .req_ack_req_i(req_ack),
    .rsp_valid_o(rsp_valid), .rsp_accept_o(rsp_accept), .rsp_trunc_o(rsp_trunc),
    .rsp_offset_o(rsp_offset), .rsp_len_o(rsp_len), .rsp_ack_o(rsp_ack),
    .md_active_o(md_active), .md_offset_o(md_offset), .md_thresh_o(md_thresh)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  int c_put = 0, c_get = 0, c_rem = 0, c_trunc = 0, c_max = 0, c_sup = 0;
  int c_len = 0, c_min = 0, c_thr = 0, m_off = 0, m_act = 0;
  int e_v = 0, e_acc = 0, e_tr = 0, e_off = 0, e_len = 0, e_ack = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int base, rem, fits, tok, acc, grant;
    e_v = 0; e_acc = 0; e_tr = 0; e_off = 0; e_len = 0; e_ack = 0;
    if (req_v) begin
      e_v   = 1;
      base  = c_rem ? int'(req_roff) : m_off;
      rem   = (base <= c_len) ? c_len - base : 0;
      fits  = (int'(req_len) <= rem);
      tok   = req_get ? c_get : c_put;
      acc   = m_act && tok && (fits || c_trunc);
      grant = fits ? int'(req_len) : rem;
      if (acc) begin
        e_acc = 1; e_tr = !fits; e_off = base; e_len = grant;
        e_ack = !req_get && req_ack && !c_sup;
        if (!cfg_we) begin
          if (!c_rem) m_off = m_off + grant;
          if (c_thr != INF && c_thr != 0) begin
            c_thr = c_thr - 1;
            if (c_thr == 0) m_act = 0;
          end
          if (c_max && !c_rem && (c_len - m_off) < c_min) m_act = 0;
        end
      end
    end
    if (cfg_we) begin
      case (cfg_addr)
        2'd0: begin
          c_put = cfg_wdata[0]; c_get = cfg_wdata[1]; c_rem = cfg_wdata[2];
          c_trunc = cfg_wdata[3]; c_max = cfg_wdata[4]; c_sup = cfg_wdata[5];
          m_off = 0; m_act = (c_thr != 0);
        end
        2'd1: c_thr = int'(cfg_wdata) & INF;
        2'd2: c_min = int'(cfg_wdata);
        default: c_len = int'(cfg_wdata);
      endcase
    end
  endtask

  // inputs are set after a negedge; compare at the following negedge
  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rsp_valid",  rsp_valid,  e_v);
    chk(tag, "rsp_accept", rsp_accept, e_acc);
    chk(tag, "rsp_trunc",  rsp_trunc,  e_tr);
    chk(tag, "rsp_offset", rsp_offset, e_off);
    chk(tag, "rsp_len",    rsp_len,    e_len);
    chk(tag, "rsp_ack",    rsp_ack,    e_ack);
    chk(tag, "md_active",  md_active,  m_act);
    chk(tag, "md_offset",  md_offset,  m_off);
    chk(tag, "md_thresh",  md_thresh,  c_thr);
    cfg_we = 1'b0; req_v = 1'b0;
  endtask

  task automatic wr(int addr, int data, string tag);
    cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = LW'(data);
    tick(tag);
  endtask

  task automatic op(bit get, int len, int roff, bit ack, string tag);
    req_v = 1'b1; req_get = get; req_len = LW'(len); req_roff = LW'(roff); req_ack = ack;
    tick(tag);
  endtask

  task automatic arm(int len, int thr, int minf, int ctrl);
    wr(3, len,  "R13");
    wr(1, thr,  "R13");
    wr(2, minf, "R13");
    wr(0, ctrl, "R13");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tick("R1");
    op(0, 4, 0, 1, "R3");                 // before arming
    // local offset, put+get, threshold 3
    arm(100, 3, 0, 'h03);
    op(0, 30, 0, 1, "R6");                // R11 ack for put
    op(1, 20, 0, 1, "R11");               // get never acks
    tick("R12");                          // idle cycle, no response
    op(0, 60, 0, 0, "R8");                // remaining 50
    op(0, 50, 0, 0, "R4");                // exact fit, threshold hits 0
    op(0, 1, 0, 0, "R3");
    // put only, truncation, ack suppress, infinite threshold
    arm(40, INF, 0, 'h29);
    op(1, 5, 0, 0, "R2");
    op(0, 25, 0, 1, "R5");                // suppressed ack, thresh stays
    op(0, 25, 0, 0, "R9");                // cut to 15
    op(0, 5, 0, 0, "R9");                 // cut to 0
    // remote offset, put+get, no truncation
    arm(50, 6, 0, 'h07);
    op(0, 30, 10, 0, "R7");
    op(1, 10, 45, 0, "R7");               // R8 oversize with remote base
    op(1, 1, 60, 0, "R8");                // base past end
    op(1, 5, 45, 0, "R7");
    // get only
    arm(50, INF, 0, 'h02);
    op(0, 5, 0, 0, "R2");
    // max-size rule, local
    arm(50, INF, 10, 'h11);
    op(0, 35, 0, 0, "R10");               // 15 left, still active
    op(0, 5, 0, 0, "R10");                // 10 left, not below
    op(0, 1, 0, 0, "R10");                // 9 left -> inactive
    op(0, 1, 0, 0, "R3");
    // max-size rule ignored with remote offset
    arm(50, INF, 10, 'h15);
    op(0, 5, 45, 0, "R10");
    // threshold 0 at arming leaves descriptor inactive
    arm(50, 0, 0, 'h03);
    op(0, 5, 0, 0, "R13");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule